// File: doc/BRIEF.md
# Operand-Gated Array Multiplier

This block multiplies two unsigned M-bit operands into a 2M-bit product. The product comes from a grid of full-adder cells. Each cell has gates on its inputs and a multiplexer on its sum output. A single operand bit drives both the gates and the multiplexer. When that bit is zero, the cell's adder inputs are forced low, so the adder does not toggle. The cell then passes the partial sum from the previous stage straight through and drives its carry to zero.

A parameter chooses which operand drives the gating:

- **Column mode.** Bit i of the multiplicand `a` controls every cell that handles that bit. The array is carry-save, so carries stay in their column and sums shift down. A final ripple stage resolves the upper half of the product.
- **Row mode.** Bit j of the multiplier `b` controls a whole row. Each row is a ripple adder that adds `a` into a running accumulator at offset j. A zero bit in `b` leaves the accumulator unchanged, while the rows for nonzero bits still add.

An optional output register captures the product when `load_en` is high. This lets a hold or retry controller decide when a result is taken.

Top module: `bypass_mul`

## Requirements
- R1: In column mode the combinational product equals the unsigned product a × b for every operand pair, including all-zero and all-one operands.
- R2: In row mode the combinational product equals the unsigned product a × b for every operand pair, including all-zero and all-one operands.
- R3: A cell whose controlling bit is 0 drives its carry output to 0. Products with sparse or alternating operand bits therefore stay exact.
- R4: In column mode the cells handling multiplicand bit i are active exactly when a[i] is 1. With a equal to zero no cell is active and the product is 0.
- R5: In row mode the cells of row j are active exactly when b[j] is 1. Rows for nonzero bits that follow bypassed rows still contribute.
- R6: While the synchronous active-high reset `rst` is high at a rising clock edge, the registered product becomes 0 after that edge.
- R7: With `load_en` high at a rising edge, the registered product shows the product of the operands present at that edge.
- R8: With `load_en` low, the registered product keeps its value even when the operands change.
- R9: An instance with M = 4 meets R1 and R2 for all 256 operand pairs. An instance with M = 16 meets them as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| load_en | input | 1 | Captures the current product into the output register |
| a | input | M | Unsigned multiplicand (gating operand in column mode) |
| b | input | M | Unsigned multiplier (gating operand in row mode) |
| product | output | 2M | Product, registered when REG_OUT is 1, otherwise combinational |

## Verification
The checks assume that `a` and `b` are stable and known at every rising edge, because the product is checked against a reference on each edge. They also assume that `load_en` is a known level outside reset. The bench changes operands and `load_en` only on falling edges and drives every input from time zero, so no sampled edge sees an X or a half-updated operand. The register-capture properties take the previous cycle's operands as the ones that were loaded. For that reason, the bench holds the operands for a full cycle around each load pulse.

// File: rtl/bypass_mul_pkg.sv
package bypass_mul_pkg;

  // Which operand gates the adder cells
  typedef enum logic {
    BYP_COL = 1'b0,  // multiplicand bit per column
    BYP_ROW = 1'b1   // multiplier bit per row
  } byp_mode_e;

endpackage

// File: rtl/bypass_fa_cell.sv
// Full adder with input gating and a sum bypass multiplexer.
module bypass_fa_cell (
  input  logic en,
  input  logic sum_in,
  input  logic pp,
  input  logic cin,
  output logic sum_out,
  output logic cout
);

  logic g_sum, g_pp, g_cin;
  logic fa_s, fa_c;

  // Gate the inputs so that an idle adder sees constant zeros
  assign g_sum = sum_in & en;
  assign g_pp  = pp & en;
  assign g_cin = cin & en;

  assign fa_s = g_sum ^ g_pp ^ g_cin;
  assign fa_c = (g_sum & g_pp) | (g_cin & (g_sum ^ g_pp));

  // Bypassed: forward the incoming partial sum, kill the carry
  assign sum_out = en ? fa_s : sum_in;
  assign cout    = en & fa_c;

endmodule

// File: rtl/bypass_col_array.sv
// Carry-save array, cells gated per multiplicand bit.
// Cell (i,j) sits at flat index j*M+i and has weight i+j.
module bypass_col_array #(
  parameter int M = 16
) (
  input  logic [M-1:0]   a,
  input  logic [M-1:0]   b,
  output logic [2*M-1:0] prod,
  output logic [M*M-1:0] cell_en,
  output logic [M*M-1:0] cell_cout
);

  localparam int NCELL = M * M;

  wire [NCELL-1:0] s_f;
  wire [NCELL-1:0] c_f;
  wire [M-1:0]     hi_x;
  wire [M-1:0]     hi_y;

  for (genvar j = 0; j < M; j++) begin : g_row
    for (genvar i = 0; i < M; i++) begin : g_col
      localparam int IDX = j * M + i;
      wire s_in;
      wire c_in;

      if (j == 0) begin : g_first
        assign s_in = 1'b0;
        assign c_in = 1'b0;
      end else begin : g_next
        if (i == M - 1) begin : g_edge
          assign s_in = 1'b0;
        end else begin : g_inner
          assign s_in = s_f[(j-1)*M + i + 1];
        end
        assign c_in = c_f[(j-1)*M + i];
      end

      bypass_fa_cell u_cell (
        .en      (a[i]),
        .sum_in  (s_in),
        .pp      (a[i] & b[j]),
        .cin     (c_in),
        .sum_out (s_f[IDX]),
        .cout    (c_f[IDX])
      );

      assign cell_en[IDX]   = a[i];
      assign cell_cout[IDX] = c_f[IDX];
    end

    // Column 0 of row j settles product bit j
    assign prod[j] = s_f[j*M];
  end

  // Final carry-propagate stage for the upper half
  for (genvar k = 0; k < M; k++) begin : g_hi
    if (k == M - 1) begin : g_top
      assign hi_x[k] = 1'b0;
    end else begin : g_low
      assign hi_x[k] = s_f[(M-1)*M + k + 1];
    end
    assign hi_y[k] = c_f[(M-1)*M + k];
  end

  assign prod[2*M-1:M] = hi_x + hi_y;

endmodule

// File: rtl/bypass_row_array.sv
// Ripple rows, each gated by one multiplier bit.
// Row j adds a into the accumulator at offset j.
module bypass_row_array #(
  parameter int M = 16
) (
  input  logic [M-1:0]   a,
  input  logic [M-1:0]   b,
  output logic [2*M-1:0] prod,
  output logic [M*M-1:0] cell_en,
  output logic [M*M-1:0] cell_cout
);

  localparam int PW = 2 * M;

  wire [(M+1)*PW-1:0] acc_f;
  wire [M*M-1:0]      c_f;

  assign acc_f[PW-1:0] = '0;

  for (genvar j = 0; j < M; j++) begin : g_row
    for (genvar i = 0; i < M; i++) begin : g_cell
      localparam int IDX = j * M + i;
      wire c_in;

      if (i == 0) begin : g_lsb
        assign c_in = 1'b0;
      end else begin : g_chain
        assign c_in = c_f[IDX - 1];
      end

      bypass_fa_cell u_cell (
        .en      (b[j]),
        .sum_in  (acc_f[j*PW + i + j]),
        .pp      (a[i] & b[j]),
        .cin     (c_in),
        .sum_out (acc_f[(j+1)*PW + i + j]),
        .cout    (c_f[IDX])
      );

      assign cell_en[IDX]   = b[j];
      assign cell_cout[IDX] = c_f[IDX];
    end

    // Bits outside the row's adders pass unchanged; the carry-out lands at j+M
    for (genvar k = 0; k < PW; k++) begin : g_pass
      if (k < j || k > j + M) begin : g_thru
        assign acc_f[(j+1)*PW + k] = acc_f[j*PW + k];
      end else if (k == j + M) begin : g_cout
        assign acc_f[(j+1)*PW + k] = c_f[j*M + M - 1];
      end
    end
  end

  assign prod = acc_f[M*PW +: PW];

endmodule

// File: rtl/bypass_mul.sv
module bypass_mul #(
  parameter int                          M       = 16,
  parameter bypass_mul_pkg::byp_mode_e   MODE    = bypass_mul_pkg::BYP_COL,
  parameter bit                          REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_en,
  input  logic [M-1:0]   a,
  input  logic [M-1:0]   b,
  output logic [2*M-1:0] product
);

  localparam int PW    = 2 * M;
  localparam int NCELL = M * M;

  logic [PW-1:0]    comb_prod;
  logic [NCELL-1:0] cell_en;
  logic [NCELL-1:0] cell_cout;

  if (MODE == bypass_mul_pkg::BYP_COL) begin : g_col
    bypass_col_array #(.M(M)) u_array (
      .a         (a),
      .b         (b),
      .prod      (comb_prod),
      .cell_en   (cell_en),
      .cell_cout (cell_cout)
    );
  end else begin : g_row
    bypass_row_array #(.M(M)) u_array (
      .a         (a),
      .b         (b),
      .prod      (comb_prod),
      .cell_en   (cell_en),
      .cell_cout (cell_cout)
    );
  end

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q <= '0;
      end else if (load_en) begin
        prod_q <= comb_prod;
      end
    end
    assign product = prod_q;
  end else begin : g_comb
    assign product = comb_prod;
  end

endmodule

// File: rtl/bypass_mul_chk.sv
module bypass_mul_chk #(
  parameter int                        M       = 16,
  parameter bypass_mul_pkg::byp_mode_e MODE    = bypass_mul_pkg::BYP_COL,
  parameter bit                        REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst,
  input logic           load_en,
  input logic [M-1:0]   a,
  input logic [M-1:0]   b,
  input logic [2*M-1:0] product,
  input logic [2*M-1:0] comb_prod,
  input logic [M*M-1:0] cell_en,
  input logic [M*M-1:0] cell_cout
);

  logic [2*M-1:0] ref_prod;
  assign ref_prod = {{M{1'b0}}, a} * {{M{1'b0}}, b};

  AST_NO_STALE_CARRY: assert property (@(posedge clk) disable iff (rst)
    (cell_cout & ~cell_en) == '0); // R3

  if (MODE == bypass_mul_pkg::BYP_COL) begin : g_col
    AST_COL_PRODUCT: assert property (@(posedge clk) disable iff (rst)
      comb_prod == ref_prod); // R1
    AST_COL_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
      (a == '0) |-> (cell_en == '0)); // R4
  end else begin : g_row
    AST_ROW_PRODUCT: assert property (@(posedge clk) disable iff (rst)
      comb_prod == ref_prod); // R2
    AST_ROW_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
      (b == '0) |-> (cell_en == '0)); // R5
  end

  if (REG_OUT) begin : g_reg
    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (product == '0)); // R6
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (product == $past(ref_prod))); // R7
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(product)); // R8
  end

endmodule

bind bypass_mul bypass_mul_chk #(
  .M(M), .MODE(MODE), .REG_OUT(REG_OUT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .load_en   (load_en),
  .a         (a),
  .b         (b),
  .product   (product),
  .comb_prod (comb_prod),
  .cell_en   (cell_en),
  .cell_cout (cell_cout)
);

// File: tb/bypass_mul_tb.sv
`timescale 1ns/1ps
module bypass_mul_tb_top;

  import bypass_mul_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [31:0] p_col16, p_row16;
  logic [7:0]  p_col4, p_row4;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bypass_mul #(.M(16), .MODE(BYP_COL), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .load_en(load_en), .a(a16), .b(b16), .product(p_col16));
  bypass_mul #(.M(16), .MODE(BYP_ROW), .REG_OUT(1'b1)) dut_row_i (
    .clk(clk), .rst(rst), .load_en(load_en), .a(a16), .b(b16), .product(p_row16));
  bypass_mul #(.M(4), .MODE(BYP_COL), .REG_OUT(1'b1)) dut_c4_i (
    .clk(clk), .rst(rst), .load_en(load_en), .a(a4), .b(b4), .product(p_col4));
  bypass_mul #(.M(4), .MODE(BYP_ROW), .REG_OUT(1'b1)) dut_r4_i (
    .clk(clk), .rst(rst), .load_en(load_en), .a(a4), .b(b4), .product(p_row4));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  // Load operands on a falling edge, capture on the rising edge, sample at the next falling edge
  task automatic mul16(input logic [15:0] x, input logic [15:0] y, input string rc, input string rr);
    logic [31:0] exp;
    exp = {16'b0, x} * {16'b0, y};
    @(negedge clk);
    a16 = x; b16 = y; load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
    check(rc, p_col16, exp);
    check(rr, p_row16, exp);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1'b1; load_en = 1'b1; a16 = 16'hFFFF; b16 = 16'hFFFF; a4 = 4'hF; b4 = 4'hF;
    @(negedge clk);
    check("R6 col16", p_col16, 32'h0);
    check("R6 row16", p_row16, 32'h0);
    check("R6 col4", {24'h0, p_col4}, 32'h0);
    rst = 1'b0; load_en = 1'b0;
  endtask

  task automatic test_corners();
    mul16(16'h0000, 16'h0000, "R1 zero", "R2 zero");
    mul16(16'hFFFF, 16'hFFFF, "R1 all-ones", "R2 all-ones");
    mul16(16'h0000, 16'hBEEF, "R4 a=0", "R2 a=0");
    mul16(16'h1234, 16'h0000, "R1 b=0", "R5 b=0");
    mul16(16'hAAAA, 16'hFFFF, "R3 alt a", "R3 alt a row");
    mul16(16'hFFFF, 16'h5555, "R3 alt b", "R3 alt b row");
    mul16(16'h8001, 16'hFFFF, "R3 sparse a", "R5 sparse b row");
    mul16(16'hFFFF, 16'h8000, "R1 top b", "R5 late row only");
  endtask

  task automatic test_patterns();
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mul16(lfsr[15:0], lfsr[31:16], "R1 pattern", "R2 pattern");
    end
  endtask

  task automatic test_hold();
    logic [31:0] held;
    mul16(16'h0123, 16'h4567, "R7 load col", "R7 load row");
    held = {16'h0, 16'h0123} * {16'h0, 16'h4567};
    @(negedge clk);
    a16 = 16'hFFFF; b16 = 16'hFFFF; load_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold col", p_col16, held);
    check("R8 hold row", p_row16, held);
  endtask

  task automatic test_small();
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        logic [7:0] exp;
        exp = 8'(x * y);
        @(negedge clk);
        a4 = 4'(x); b4 = 4'(y); load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        check("R9 col4", {24'h0, p_col4}, {24'h0, exp});
        check("R9 row4", {24'h0, p_row4}, {24'h0, exp});
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    test_corners();
    test_patterns();
    test_hold();
    test_small();
    finish_run();
  end

endmodule